// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Sequencer

This block copies a run of bytes from one memory region to another without help from the processor. A start command loads a source pointer, a destination pointer and a byte count. The sequencer then alternates two kinds of bus cycle for every byte. In the fetch cycle it pulls the memory read strobe low at the source pointer and captures the returned byte in an internal 8-bit holding register. In the store cycle it pulls the memory write strobe low at the destination pointer and drives that byte on the data bus.

The source pointer lives in pointer slot 0 and the destination pointer in pointer slot 1. Each pointer advances by one after its own cycle. The count drops by one after each store. When the count reaches zero, a one-clock terminal-count pulse follows the final store and the sequencer returns to idle. Only byte-wide copies are possible, because the holding register is one byte.

Top module: `m2m_copy_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, busy and tc are 0, mem_rd_n and mem_wr_n are 1, and data_oe is 0.
- R2: A start sampled high while idle with a nonzero byte_cnt makes the next cycle a fetch cycle: mem_rd_n is 0 and mem_addr equals src_base.
- R3: Each byte is one fetch cycle followed directly by one store cycle. In the store cycle mem_wr_n is 0 and data_out equals the byte that data_in presented during the fetch. The two strobes are never low together.
- R4: data_oe is 1 only in store cycles and is 0 in every fetch cycle.
- R5: The fetch address of byte i is src_base+i and the store address is dst_base+i, both taken modulo 2^AW, so pointers wrap from all ones to zero.
- R6: After the store cycle of the last byte, tc is 1 for exactly one clock with both strobes high. In the next cycle busy and tc are 0.
- R7: A start while busy is ignored. The running copy keeps its addresses, data and length.
- R8: A start with byte_cnt equal to 0 is ignored. busy stays 0 and no strobe goes low.
- R9: A copy of N bytes takes exactly 2N back-to-back bus cycles, with no idle cycle between bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Copy command, sampled each rising edge |
| src_base | input | AW | First source address |
| dst_base | input | AW | First destination address |
| byte_cnt | input | CW | Number of bytes to copy |
| data_in | input | 8 | Read data returned by memory during a fetch cycle |
| mem_addr | output | AW | Memory address for the current bus cycle |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| data_out | output | 8 | Write data, valid in store cycles |
| data_oe | output | 1 | Data bus drive enable; 0 leaves the bus released |
| busy | output | 1 | A copy is in progress, including the tc cycle |
| tc | output | 1 | One-clock terminal-count pulse |

## Verification
The assertions assume memory answers a fetch within the same cycle. They also assume reset is held for at least one clock before the sequencer's own history is trusted. Two-cycle address comparisons only start once two fetch cycles have been observed. The stimulus keeps to these assumptions: a combinational memory model serves reads from a bench array, and each scenario starts with a reset of two clocks. Source and destination regions never overlap, so expected bytes can be taken from the initial memory pattern.

// File: rtl/m2m_pkg.sv
package m2m_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_STORE = 2'd2,
        PH_TERM  = 2'd3
    } phase_e;

    localparam int NUM_PTR = 2;
    localparam int PTR_SRC = 0;
    localparam int PTR_DST = 1;
    localparam int BYTE_W  = 8;

    typedef struct packed {
        logic rd_n;
        logic wr_n;
        logic oe;
        logic term;
    } bus_ctl_t;

    function automatic bus_ctl_t decode_ctl(input phase_e ph);
        bus_ctl_t c;
        c.rd_n = 1'b1;
        c.wr_n = 1'b1;
        c.oe   = 1'b0;
        c.term = 1'b0;
        case (ph)
            PH_FETCH: c.rd_n = 1'b0;
            PH_STORE: begin
                c.wr_n = 1'b0;
                c.oe   = 1'b1;
            end
            PH_TERM:  c.term = 1'b1;
            default:  ;
        endcase
        return c;
    endfunction

    function automatic logic [NUM_PTR-1:0] step_mask(input phase_e ph);
        logic [NUM_PTR-1:0] m;
        m = '0;
        m[PTR_SRC] = (ph == PH_FETCH);
        m[PTR_DST] = (ph == PH_STORE);
        return m;
    endfunction

endpackage

// File: rtl/m2m_ptr.sv
module m2m_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr + AW'(1);
        end
    end
endmodule

// File: rtl/m2m_cnt.sv
module m2m_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec) begin
            remain <= remain - CW'(1);
        end
    end

    assign last = (remain == CW'(1));
endmodule

// File: rtl/m2m_fsm.sv
module m2m_fsm
    import m2m_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   len_nonzero,
    input  logic   last,
    output logic   accept,
    output phase_e phase
);
    phase_e phase_nx;

    assign accept = (phase == PH_IDLE) && start && len_nonzero;

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE:  if (accept) phase_nx = PH_FETCH;
            PH_FETCH: phase_nx = PH_STORE;
            PH_STORE: phase_nx = last ? PH_TERM : PH_FETCH;
            PH_TERM:  phase_nx = PH_IDLE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nx;
        end
    end
endmodule

// File: rtl/m2m_copy_seq.sv
module m2m_copy_seq
    import m2m_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     src_base,
    input  logic [AW-1:0]     dst_base,
    input  logic [CW-1:0]     byte_cnt,
    input  logic [BYTE_W-1:0] data_in,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [BYTE_W-1:0] data_out,
    output logic              data_oe,
    output logic              busy,
    output logic              tc
);
    phase_e             phase;
    logic               accept;
    logic               last;
    bus_ctl_t           ctl;
    logic [NUM_PTR-1:0] steps;
    logic [AW-1:0]      base  [NUM_PTR];
    logic [AW-1:0]      cur   [NUM_PTR];
    logic [BYTE_W-1:0]  hold;

    m2m_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .len_nonzero (byte_cnt != '0),
        .last        (last),
        .accept      (accept),
        .phase       (phase)
    );

    m2m_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (byte_cnt),
        .dec      (phase == PH_STORE),
        .last     (last)
    );

    assign base[PTR_SRC] = src_base;
    assign base[PTR_DST] = dst_base;
    assign steps         = step_mask(phase);

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        m2m_ptr #(.AW(AW)) u_ptr (
            .clk      (clk),
            .rst      (rst),
            .load     (accept),
            .load_val (base[g]),
            .step     (steps[g]),
            .ptr      (cur[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (phase == PH_FETCH) begin
            hold <= data_in;
        end
    end

    assign ctl      = decode_ctl(phase);
    assign mem_rd_n = ctl.rd_n;
    assign mem_wr_n = ctl.wr_n;
    assign data_oe  = ctl.oe;
    assign tc       = ctl.term;
    assign busy     = (phase != PH_IDLE);
    assign data_out = hold;
    assign mem_addr = (phase == PH_STORE) ? cur[PTR_DST] : cur[PTR_SRC];
endmodule

// File: rtl/m2m_copy_chk.sv
module m2m_copy_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd_n,
    input logic          mem_wr_n,
    input logic          data_oe,
    input logic          busy,
    input logic          tc
);
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n));

    p_fetch_then_store_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |=> !mem_wr_n);

    p_store_follow_r9: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |=> (!mem_rd_n || tc));

    p_oe_off_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |-> !data_oe);

    p_oe_in_store_r4: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !mem_wr_n);

    p_src_advance_r5: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n && $past(!mem_rd_n, 2)) |-> mem_addr == $past(mem_addr, 2) + AW'(1));

    p_tc_single_r6: assert property (@(posedge clk) disable iff (rst)
        tc |=> (!tc && !busy));

    p_tc_after_store_r6: assert property (@(posedge clk) disable iff (rst)
        tc |-> $past(!mem_wr_n));

    p_busy_held_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !tc) |=> busy);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (mem_rd_n && mem_wr_n && !data_oe && !tc));
endmodule

bind m2m_copy_seq m2m_copy_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mem_addr (mem_addr),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .data_oe  (data_oe),
    .busy     (busy),
    .tc       (tc)
);

// File: tb/test_m2m_copy_seq.sv
`timescale 1ns/1ps
module test_m2m_copy_seq;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = '0;
    logic [AW-1:0] dst_base = '0;
    logic [CW-1:0] byte_cnt = '0;
    logic [7:0]    data_in;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_n, mem_wr_n, data_oe, busy, tc;
    logic [7:0]    data_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic [7:0] mem [0:1023];

    always #5 clk = ~clk;

    m2m_copy_seq #(.AW(AW), .CW(CW)) i_m2m_copy_seq (
        .clk(clk), .rst(rst), .start(start), .src_base(src_base),
        .dst_base(dst_base), .byte_cnt(byte_cnt), .data_in(data_in),
        .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .data_out(data_out), .data_oe(data_oe), .busy(busy), .tc(tc)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return (a[7:0] * 8'd29) ^ {6'd0, a[9:8]} ^ 8'h5A;
    endfunction

    assign data_in = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 1024; k++) mem[k] <= pat(k[15:0]);
        end else if (!mem_wr_n) begin
            mem[mem_addr[9:0]] <= data_out;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0;
        @(negedge clk);
        check(!busy && !tc && mem_rd_n && mem_wr_n && !data_oe, "R1", "idle in reset",
              {busy, tc, mem_rd_n, mem_wr_n, data_oe}, 5'b00110);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !tc && mem_rd_n && mem_wr_n && !data_oe, "R1", "idle after reset",
              {busy, tc, mem_rd_n, mem_wr_n, data_oe}, 5'b00110);
    endtask

    // copy n bytes; optionally pulse a junk start during byte inj (R7)
    task automatic run_copy(input logic [15:0] src, input logic [15:0] dst,
                            input int n, input int inj);
        logic [15:0] sa, da;
        do_reset();
        src_base = src; dst_base = dst; byte_cnt = n[CW-1:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            sa = src + i[15:0];
            da = dst + i[15:0];
            check(!mem_rd_n && mem_wr_n, (i == 0) ? "R2" : "R9", "fetch strobe",
                  {mem_rd_n, mem_wr_n}, 2'b01);
            check(mem_addr == sa, (i == 0) ? "R2" : "R5", "fetch addr", mem_addr, sa);
            check(!data_oe, "R4", "oe in fetch", data_oe, 0);
            if (i == inj) begin
                start = 1'b1; src_base = 16'h0300; dst_base = 16'h0380; byte_cnt = 5;
            end
            @(negedge clk);
            start = 1'b0;
            check(!mem_wr_n && mem_rd_n, "R3", "store strobe", {mem_rd_n, mem_wr_n}, 2'b10);
            check(mem_addr == da, "R5", "store addr", mem_addr, da);
            check(data_out == pat(sa), "R3", "store data", data_out, pat(sa));
            check(data_oe, "R4", "oe in store", data_oe, 1);
            @(negedge clk);
        end
        check(tc && busy && mem_rd_n && mem_wr_n, "R6", "tc cycle",
              {tc, busy, mem_rd_n, mem_wr_n}, 4'b1111);
        @(negedge clk);
        check(!tc && !busy, "R6", "idle after tc", {tc, busy}, 0);
        for (int i = 0; i < n; i++) begin
            sa = src + i[15:0];
            da = dst + i[15:0];
            check(mem[da[9:0]] == pat(sa), (inj >= 0) ? "R7" : "R3", "dest byte",
                  mem[da[9:0]], pat(sa));
        end
        if (inj >= 0)
            check(mem[10'h380] == pat(16'h0380), "R7", "junk dest untouched",
                  mem[10'h380], pat(16'h0380));
    endtask

    task automatic t_zero_len();
        do_reset();
        src_base = 16'h0010; dst_base = 16'h0020; byte_cnt = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(!busy && mem_rd_n && mem_wr_n && !tc, "R8", "zero count ignored",
                  {busy, mem_rd_n, mem_wr_n, tc}, 4'b0110);
            @(negedge clk);
        end
        check(mem[10'h020] == pat(16'h0020), "R8", "dest untouched",
              mem[10'h020], pat(16'h0020));
    endtask

    initial begin
        do_reset();
        run_copy(16'h0040, 16'h0100, 1, -1);
        run_copy(16'h0005, 16'h0200, 7, -1);
        run_copy(16'hFFFE, 16'h01F0, 4, -1);   // R5 source wrap
        run_copy(16'h0080, 16'hFFFD, 5, -1);   // R5 destination wrap
        run_copy(16'h0120, 16'h0160, 6, 2);    // R7 start while busy
        t_zero_len();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule